// File: doc/BRIEF.md
# DMA Request Handshake Bridge

This block joins a two-channel serial controller to an ISA-style host bus for DMA work. Each controller channel owns two request pins: one asks for transmit transfers, the other for receive-or-transmit transfers. That makes four request lines, and each becomes one host DMA request line (`drq`). A line is set when its pin rises. It stays set until the host returns the matching acknowledge (`dack`) for one bus cycle. Per-channel enable bits in a host control register decide whether a channel's request lines are driven at all. While a channel is disabled its lines are modelled as undriven (`drq_oe` low). The block holds no pending request for a disabled channel.

When the host DMA controller raises terminal count during an acknowledged cycle on an enabled channel, the block records it in a per-channel sticky status bit. The interrupt output is the OR of these status bits, gated by a master interrupt enable. Software reads the status register, then writes ones to clear the bits it has handled. The host interface is a simple strobe model: single-cycle write strobes, and combinational read data while the read strobe is high.

Top module: `dma_req_bridge`

## Requirements
- R1: After a cycle with `rst` high, `drq_oe`, `drq` and `irq` are all 0, and both the control register (offset 4) and the status register (offset 5) read as 0.
- R2: A write to offset 4 sets channel A's DMA enable from data bit 7 and channel B's from data bit 6. From the following cycle, `drq_oe` is high on pairs 0 and 1 when A is enabled and on pairs 2 and 3 when B is enabled, and `drq` is low on every pair that has just been enabled.
- R3: A rising edge on `ctl_req[p]` for an enabled pair sets `drq[p]` in the next cycle. The line then stays high for as long as no acknowledge arrives.
- R4: A cycle with `dack[p]` high releases `drq[p]` in the following cycle, and a later rising edge on the pin sets it again. If a new rising edge and `dack[p]` fall in the same cycle, `drq[p]` stays high.
- R5: A rising edge on the pin of a disabled pair is ignored. Enabling that channel afterwards does not set `drq`.
- R6: Clearing a channel's enable while its requests are pending drops its `drq` lines and `drq_oe` in the cycle after the write. Enabling it again does not restore the dropped requests.
- R7: Status bit c at offset 5 (bit 0 for channel A, bit 1 for channel B) is set when `tc` is high in the same cycle as `dack` on one of that channel's pairs while the channel is enabled. `tc` with no acknowledge, or with the acknowledge of a disabled channel, sets nothing.
- R8: Writing offset 5 clears each status bit whose data bit is 1 and leaves the others unchanged. If a capture and a clear of the same bit fall in one cycle, the bit stays set.
- R9: Control bit 0 at offset 4 is the master interrupt enable. `irq` is high exactly when this bit is 1 and at least one status bit is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset (power-up or bus reset) |
| host_addr | input | 3 | Host register offset |
| host_wr | input | 1 | Single-cycle write strobe |
| host_rd | input | 1 | Read strobe; read data is valid while it is high |
| host_wdata | input | 8 | Write data |
| host_rdata | output | 8 | Read data (0 when not reading) |
| ctl_req | input | 4 | Request pins from the controller, one per pair |
| dack | input | 4 | Host DMA acknowledge, active high, one per pair |
| tc | input | 1 | Host terminal-count strobe |
| drq | output | 4 | Host DMA request lines |
| drq_oe | output | 4 | Output enable of each request line (low means tristated) |
| irq | output | 1 | Transfer-complete interrupt |

## Verification
Two pairs of functions can meet in a single cycle. A fresh rising edge on a request pin can coincide with the acknowledge that would release it. A terminal-count capture can coincide with a software clear of the same status bit. The bench provokes both collisions on purpose: it drives the pin and `dack` together in one cycle, and it issues the status write in the same cycle as `tc` plus `dack`. In each collision the new event must win, so `drq` stays high and the status bit stays set. Both results are judged at the ports, through the request line and a status read.

// File: rtl/dbr_pkg.sv
package dbr_pkg;

    // Default geometry of the bridge
    parameter int unsigned CH_N         = 2;
    parameter int unsigned PAIRS_PER_CH = 2;
    parameter int unsigned ADDR_W       = 3;
    parameter int unsigned DATA_W       = 8;

    // Register offsets seen by the host driver
    localparam int unsigned OFS_CTRL   = 4;
    localparam int unsigned OFS_TCSTAT = 5;
    localparam int unsigned MIE_BIT    = 0;

    typedef enum logic [1:0] {
        SEL_NONE   = 2'd0,
        SEL_CTRL   = 2'd1,
        SEL_TCSTAT = 2'd2
    } reg_sel_e;

    // State held by one request slot
    typedef struct packed {
        logic pend;   // request latched, waiting for acknowledge
        logic req_q;  // pin value seen in the previous cycle
    } slot_st_t;

    // Channel enables count down from the top data bit
    function automatic int unsigned en_bit_of(int unsigned dw, int unsigned ch);
        return dw - 1 - ch;
    endfunction

    function automatic int unsigned chan_of(int unsigned pair, int unsigned per_ch);
        return pair / per_ch;
    endfunction

endpackage

// File: rtl/dbr_req_slot.sv
module dbr_req_slot
    import dbr_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic enable,
    input  logic req_pin,
    input  logic ack,
    output logic drq,
    output logic oe
);

    slot_st_t st_q, st_d;
    logic     rise;

    assign rise = req_pin & ~st_q.req_q;

    always_comb begin
        st_d.req_q = req_pin;
        // a new edge outranks an acknowledge in the same cycle
        st_d.pend  = enable & (rise | (st_q.pend & ~ack));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // a pending request is dropped as soon as its enable falls
    assign drq = st_q.pend & enable;
    assign oe  = enable;

endmodule

// File: rtl/dbr_tc_capture.sv
module dbr_tc_capture #(
    parameter int unsigned CH_N         = dbr_pkg::CH_N,
    parameter int unsigned PAIRS_PER_CH = dbr_pkg::PAIRS_PER_CH,
    localparam int unsigned PAIR_N      = CH_N * PAIRS_PER_CH
) (
    input  logic              tc,
    input  logic [PAIR_N-1:0] dack,
    input  logic [CH_N-1:0]   ch_en,
    output logic [CH_N-1:0]   tc_hit
);

    for (genvar c = 0; c < CH_N; c++) begin : g_ch
        assign tc_hit[c] = tc & ch_en[c] & (|dack[c*PAIRS_PER_CH +: PAIRS_PER_CH]);
    end

endmodule

// File: rtl/dbr_host_regs.sv
module dbr_host_regs
    import dbr_pkg::*;
#(
    parameter int unsigned CH_N   = dbr_pkg::CH_N,
    parameter int unsigned ADDR_W = dbr_pkg::ADDR_W,
    parameter int unsigned DATA_W = dbr_pkg::DATA_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic              host_wr,
    input  logic              host_rd,
    input  logic [DATA_W-1:0] host_wdata,
    output logic [DATA_W-1:0] host_rdata,
    input  logic [CH_N-1:0]   tc_hit,
    output logic [CH_N-1:0]   dma_en,
    output logic              irq_en,
    output logic [CH_N-1:0]   tc_stat
);

    reg_sel_e        sel;
    logic            wr_ctrl, wr_stat;
    logic [CH_N-1:0] en_d, clr_mask;

    always_comb begin
        sel = SEL_NONE;
        if (host_addr == ADDR_W'(OFS_CTRL)) begin
            sel = SEL_CTRL;
        end else if (host_addr == ADDR_W'(OFS_TCSTAT)) begin
            sel = SEL_TCSTAT;
        end
    end

    assign wr_ctrl = host_wr && (sel == SEL_CTRL);
    assign wr_stat = host_wr && (sel == SEL_TCSTAT);

    for (genvar c = 0; c < CH_N; c++) begin : g_bits
        assign en_d[c]     = host_wdata[en_bit_of(DATA_W, c)];
        assign clr_mask[c] = wr_stat & host_wdata[c];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            dma_en  <= '0;
            irq_en  <= 1'b0;
            tc_stat <= '0;
        end else begin
            if (wr_ctrl) begin
                dma_en <= en_d;
                irq_en <= host_wdata[MIE_BIT];
            end
            // capture is applied after the clear so that it wins
            tc_stat <= (tc_stat & ~clr_mask) | tc_hit;
        end
    end

    always_comb begin
        host_rdata = '0;
        if (host_rd) begin
            unique case (sel)
                SEL_CTRL: begin
                    for (int c = 0; c < CH_N; c++) begin
                        host_rdata[en_bit_of(DATA_W, c)] = dma_en[c];
                    end
                    host_rdata[MIE_BIT] = irq_en;
                end
                SEL_TCSTAT: host_rdata[CH_N-1:0] = tc_stat;
                default:    host_rdata = '0;
            endcase
        end
    end

endmodule

// File: rtl/dma_req_bridge.sv
module dma_req_bridge
    import dbr_pkg::*;
#(
    parameter int unsigned CH_N         = dbr_pkg::CH_N,
    parameter int unsigned PAIRS_PER_CH = dbr_pkg::PAIRS_PER_CH,
    parameter int unsigned ADDR_W       = dbr_pkg::ADDR_W,
    parameter int unsigned DATA_W       = dbr_pkg::DATA_W,
    localparam int unsigned PAIR_N      = CH_N * PAIRS_PER_CH
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic              host_wr,
    input  logic              host_rd,
    input  logic [DATA_W-1:0] host_wdata,
    output logic [DATA_W-1:0] host_rdata,
    input  logic [PAIR_N-1:0] ctl_req,
    input  logic [PAIR_N-1:0] dack,
    input  logic              tc,
    output logic [PAIR_N-1:0] drq,
    output logic [PAIR_N-1:0] drq_oe,
    output logic              irq
);

    logic [CH_N-1:0] dma_en;
    logic [CH_N-1:0] tc_stat;
    logic [CH_N-1:0] tc_hit;
    logic            irq_en;

    dbr_host_regs #(
        .CH_N   (CH_N),
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_regs (
        .clk        (clk),
        .rst        (rst),
        .host_addr  (host_addr),
        .host_wr    (host_wr),
        .host_rd    (host_rd),
        .host_wdata (host_wdata),
        .host_rdata (host_rdata),
        .tc_hit     (tc_hit),
        .dma_en     (dma_en),
        .irq_en     (irq_en),
        .tc_stat    (tc_stat)
    );

    dbr_tc_capture #(
        .CH_N         (CH_N),
        .PAIRS_PER_CH (PAIRS_PER_CH)
    ) u_tc (
        .tc     (tc),
        .dack   (dack),
        .ch_en  (dma_en),
        .tc_hit (tc_hit)
    );

    for (genvar p = 0; p < PAIR_N; p++) begin : g_slot
        dbr_req_slot u_slot (
            .clk     (clk),
            .rst     (rst),
            .enable  (dma_en[chan_of(p, PAIRS_PER_CH)]),
            .req_pin (ctl_req[p]),
            .ack     (dack[p]),
            .drq     (drq[p]),
            .oe      (drq_oe[p])
        );
    end

    assign irq = irq_en & (|tc_stat);

endmodule

// File: rtl/dbr_checker.sv
module dbr_checker #(
    parameter int unsigned PAIR_N = 4
) (
    input logic              clk,
    input logic              rst,
    input logic              host_wr,
    input logic [PAIR_N-1:0] ctl_req,
    input logic [PAIR_N-1:0] dack,
    input logic              tc,
    input logic [PAIR_N-1:0] drq,
    input logic [PAIR_N-1:0] drq_oe,
    input logic              irq
);

    p_reset_quiet_r1: assert property (@(posedge clk)
        rst |=> (drq_oe == '0 && drq == '0 && !irq));

    // R9: interrupt can only appear after a capture or a register write
    p_irq_cause_r9: assert property (@(posedge clk) disable iff (rst)
        $rose(irq) |-> $past(tc || host_wr));

    // R8: status is sticky until software writes
    p_irq_sticky_r8: assert property (@(posedge clk) disable iff (rst)
        irq && !host_wr |=> irq);

    for (genvar i = 0; i < PAIR_N; i++) begin : g_pair
        p_drq_driven_r2: assert property (@(posedge clk) disable iff (rst)
            drq[i] |-> drq_oe[i]);

        p_drq_hold_r3: assert property (@(posedge clk) disable iff (rst)
            drq[i] && !dack[i] && !host_wr |=> drq[i]);

        p_drq_release_r4: assert property (@(posedge clk) disable iff (rst)
            drq[i] && dack[i] && !ctl_req[i] |=> !drq[i]);

        p_drop_on_disable_r6: assert property (@(posedge clk) disable iff (rst)
            $fell(drq_oe[i]) |-> !drq[i]);
    end

endmodule

bind dma_req_bridge dbr_checker #(.PAIR_N(PAIR_N)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .host_wr (host_wr),
    .ctl_req (ctl_req),
    .dack    (dack),
    .tc      (tc),
    .drq     (drq),
    .drq_oe  (drq_oe),
    .irq     (irq)
);

// File: tb/dma_req_bridge_test.sv
module dma_req_bridge_test;

    logic       clk = 1'b0;
    logic       rst;
    logic [2:0] host_addr;
    logic       host_wr;
    logic       host_rd;
    logic [7:0] host_wdata;
    logic [7:0] host_rdata;
    logic [3:0] ctl_req;
    logic [3:0] dack;
    logic       tc;
    logic [3:0] drq;
    logic [3:0] drq_oe;
    logic       irq;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    dma_req_bridge uut (
        .clk        (clk),
        .rst        (rst),
        .host_addr  (host_addr),
        .host_wr    (host_wr),
        .host_rd    (host_rd),
        .host_wdata (host_wdata),
        .host_rdata (host_rdata),
        .ctl_req    (ctl_req),
        .dack       (dack),
        .tc         (tc),
        .drq        (drq),
        .drq_oe     (drq_oe),
        .irq        (irq)
    );

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(logic [2:0] a, logic [7:0] d);
        host_addr  = a;
        host_wdata = d;
        host_wr    = 1'b1;
        tick();
        host_wr    = 1'b0;
    endtask

    task automatic rd(logic [2:0] a, output logic [7:0] d);
        host_addr = a;
        host_rd   = 1'b1;
        #1;
        d         = host_rdata;
        host_rd   = 1'b0;
    endtask

    // control word: bit7 channel A, bit6 channel B, bit0 master irq enable
    function automatic logic [7:0] ctrl_word(logic [1:0] en, logic mie);
        return {en[0], en[1], 5'b0, mie};
    endfunction

    function automatic logic [3:0] oe_of(logic [1:0] en);
        logic [3:0] r;
        for (int p = 0; p < 4; p++) r[p] = en[p >> 1];
        return r;
    endfunction

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [7:0] d;
        rst = 1'b1; host_addr = '0; host_wr = 0; host_rd = 0; host_wdata = '0;
        ctl_req = '0; dack = '0; tc = 0;
        repeat (3) tick();
        rst = 1'b0;

        // R1 reset state
        check("R1 oe", drq_oe, 0);
        check("R1 drq", drq, 0);
        check("R1 irq", irq, 0);
        rd(3'd4, d); check("R1 ctrl", d, 0);
        rd(3'd5, d); check("R1 stat", d, 0);

        // R5 edges while disabled are ignored
        ctl_req = 4'hF; tick();
        wr(3'd4, ctrl_word(2'b11, 1'b0));
        check("R5 no drq after enable", drq, 0);
        ctl_req = '0; tick();

        // R2/R3/R4/R5 sweep over every enable combination and every pair
        for (int en = 0; en < 4; en++) begin
            wr(3'd4, ctrl_word(en[1:0], 1'b0));
            check("R2 oe", drq_oe, oe_of(en[1:0]));
            check("R2 drq low", drq, 0);
            rd(3'd4, d); check("R2 readback", d, ctrl_word(en[1:0], 1'b0));
            for (int p = 0; p < 4; p++) begin
                logic [3:0] exp;
                exp = oe_of(en[1:0]) & (4'b1 << p);
                ctl_req[p] = 1'b1; tick();
                check(en[p >> 1] ? "R3 set" : "R5 ignored", drq, exp);
                tick(); tick();
                check("R3 hold", drq, exp);
                dack[p] = 1'b1; tick();
                dack[p] = 1'b0; ctl_req[p] = 1'b0;
                check("R4 release", drq, 0);
                tick();
            end
        end

        // R4 re-request and same-cycle edge with acknowledge
        wr(3'd4, ctrl_word(2'b11, 1'b0));
        ctl_req[1] = 1; tick(); check("R4 first", drq, 4'b0010);
        dack[1] = 1; tick(); dack[1] = 0; check("R4 acked", drq, 0);
        ctl_req[1] = 0; tick(); ctl_req[1] = 1; tick();
        check("R4 again", drq, 4'b0010);
        ctl_req[1] = 0; tick();
        ctl_req[1] = 1; dack[1] = 1; tick(); dack[1] = 0;
        check("R4 edge beats ack", drq, 4'b0010);
        dack[1] = 1; tick(); dack[1] = 0; ctl_req[1] = 0;
        check("R4 plain ack", drq, 0);
        tick();

        // R6 disabling drops pending request
        ctl_req[3] = 1; tick(); check("R6 pending", drq, 4'b1000);
        wr(3'd4, ctrl_word(2'b01, 1'b0));
        check("R6 dropped", drq, 0);
        check("R6 oe off", drq_oe, 4'b0011);
        wr(3'd4, ctrl_word(2'b11, 1'b0));
        check("R6 not restored", drq, 0);
        ctl_req[3] = 0; tick();

        // R7/R9 terminal count capture on every pair
        wr(3'd4, ctrl_word(2'b11, 1'b1));
        for (int p = 0; p < 4; p++) begin
            dack[p] = 1; tc = 1; tick(); dack[p] = 0; tc = 0;
            rd(3'd5, d); check("R7 capture", d, 8'(1 << (p >> 1)));
            check("R9 irq", irq, 1);
            wr(3'd5, 8'h03);
            rd(3'd5, d); check("R8 clear", d, 0);
            check("R9 irq off", irq, 0);
        end
        tc = 1; tick(); tc = 0;
        rd(3'd5, d); check("R7 tc without dack", d, 0);
        wr(3'd4, ctrl_word(2'b01, 1'b1));
        dack[2] = 1; tc = 1; tick(); dack[2] = 0; tc = 0;
        rd(3'd5, d); check("R7 disabled channel", d, 0);
        check("R7 irq", irq, 0);

        // R8 partial clear and same-cycle capture with clear
        wr(3'd4, ctrl_word(2'b11, 1'b1));
        dack[0] = 1; dack[2] = 1; tc = 1; tick(); dack = '0; tc = 0;
        rd(3'd5, d); check("R7 both", d, 8'h03);
        wr(3'd5, 8'h01);
        rd(3'd5, d); check("R8 partial", d, 8'h02);
        host_addr = 3'd5; host_wdata = 8'h02; host_wr = 1; dack[3] = 1; tc = 1;
        tick(); host_wr = 0; dack = '0; tc = 0;
        rd(3'd5, d); check("R8 capture wins", d, 8'h02);

        // R9 sweep over status patterns and master enable
        for (int s = 0; s < 4; s++) begin
            wr(3'd5, 8'h03);
            if (s[0]) begin dack[1] = 1; tc = 1; tick(); dack = '0; tc = 0; end
            if (s[1]) begin dack[3] = 1; tc = 1; tick(); dack = '0; tc = 0; end
            for (int m = 0; m < 2; m++) begin
                wr(3'd4, ctrl_word(2'b11, m[0]));
                check("R9 gate", irq, (m == 1) && (s != 0));
            end
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule